// File: doc/BRIEF.md
# Synchronous Buck Gate-Drive Sequencer

This block is the digital control core of a half-bridge gate driver for a synchronous buck stage. It turns a three-level switching command and a three-level enable into two gate-drive requests, one for the high-side switch and one for the low-side switch. The analog front end slices both commands into one-hot levels before they reach this block. A supply-good flag, two gate-below-threshold comparator flags and a switch-node zero-cross flag also come in from the analog side.

Dead time is adaptive. One switch is released first. The other is requested only after the comparator reports that the released gate has fallen below threshold, and then only after a programmable turn-on delay. If that report never comes, a timeout lets the handover finish anyway and sets a sticky fault bit. In the middle command level the block runs diode emulation. The low side turns on, is held through a blanking window that hides ringing from the zero-cross detector, and is then released at the first zero crossing. Both switches then stay off until the command level changes.

All inputs are plain level signals. The command and enable levels and the supply-good flag are synchronous to `clk`. The comparator and zero-cross flags are asynchronous and each passes through a two-flop synchronizer. There is no streaming data path, so the block has no valid/ready handshake.

Top module: `buck_gate_seq`

## Requirements
- R1: While `rst_n` is low both drive outputs and `fault_timeout` are 0. When `supply_ok` is low at a clock edge, both drive outputs are 0 after that edge.
- R2: When the enable is at its mid level (`en_mid`=1) or its low level (`en_lo`=1) at a clock edge, both drive outputs are 0 after that edge. Only `en_hi`=1 together with `supply_ok`=1 lets the outputs switch.
- R3: `hs_drive` and `ls_drive` are never 1 in the same cycle.
- R4: Command high (`pwm_hi`=1) takes the low-side output to 0 at the next edge. The high-side output rises `TURN_ON_CYC` cycles after the first edge at which the two-flop-synchronized `ls_gate_low` flag reads 1.
- R5: Command low (`pwm_lo`=1) takes the high-side output to 0 at the next edge. The low-side output rises `TURN_ON_CYC` cycles after the first edge at which the synchronized `hs_gate_low` flag reads 1.
- R6: Command mid (`pwm_mid`=1) drops the high side and turns on the low side through the same handover as R5.
- R7: In command mid the low side, once on, stays on for `BLANK_CYC` cycles while the zero-cross flag is ignored. With the zero-cross flag held at 1, the low side is on for exactly `BLANK_CYC`+1 observed cycles when entered from low-side-on.
- R8: After blanking, the first edge that sees the synchronized `zero_cross` at 1 turns the low side off. Both outputs then stay 0 for as long as the command stays mid.
- R9: The zero-cross latch is cleared by command high or low. Moving from the latched state to command low turns the low side back on through the R5 handover.
- R10: If the awaited gate-below flag does not arrive within `TIMEOUT_CYC` cycles of waiting, the handover proceeds as if it had arrived and `fault_timeout` goes to 1.
- R11: `fault_timeout` stays 1 until reset, whatever the later commands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | 1 | Command level high (one-hot with pwm_mid, pwm_lo) |
| pwm_mid | input | 1 | Command level mid: diode emulation |
| pwm_lo | input | 1 | Command level low |
| en_hi | input | 1 | Enable level high: run (one-hot with en_mid, en_lo) |
| en_mid | input | 1 | Enable level mid: both outputs forced off |
| en_lo | input | 1 | Enable level low: driver disabled |
| supply_ok | input | 1 | Supply above its lockout threshold |
| hs_gate_low | input | 1 | Asynchronous: high-side gate below threshold |
| ls_gate_low | input | 1 | Asynchronous: low-side gate below threshold |
| zero_cross | input | 1 | Asynchronous: switch-node zero-cross detected |
| hs_drive | output | 1 | High-side drive request |
| ls_drive | output | 1 | Low-side drive request |
| fault_timeout | output | 1 | Sticky: a gate-below flag timed out |

## Verification
A wrong sequencer state shows up at the drive pins at the next clock edge. It appears as an output that rises early, late or while the other side is still requested, or as a low side that stays on past blanking or drops inside it. The bench keeps a cycle model of the handover and diode-emulation phases and compares both drive pins and the fault flag every cycle, so a wrong counter load or a missed transition is reported in the cycle it first differs. A feedback model with a four-cycle delay sets the timing of the gate-below flags, and a stuck-flag case exercises the timeout path.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_WAIT_LS_OFF,
    ST_HS_DLY,
    ST_HS_ON,
    ST_WAIT_HS_OFF,
    ST_LS_DLY,
    ST_LS_ON,
    ST_DE_BLANK,
    ST_DE_MON,
    ST_DE_DONE
  } seq_st_e;

  typedef enum logic [1:0] {
    TGT_HS,
    TGT_LS,
    TGT_DE
  } tgt_e;
endpackage

// File: rtl/bgs_sync.sv
module bgs_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/bgs_decode.sv
module bgs_decode
  import bgs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_hi,
  input  logic pwm_mid,
  input  logic pwm_lo,
  input  logic en_hi,
  input  logic en_mid,
  input  logic en_lo,
  input  logic supply_ok,
  output tgt_e tgt,
  output logic run_ok
);
  always_comb begin
    if (pwm_hi)      tgt = TGT_HS;
    else if (pwm_lo) tgt = TGT_LS;
    else             tgt = TGT_DE;
  end

  assign run_ok = supply_ok & en_hi & ~en_mid & ~en_lo;

  pwm_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({pwm_hi, pwm_mid, pwm_lo}));

  en_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({en_hi, en_mid, en_lo}));
endmodule

// File: rtl/bgs_fsm.sv
module bgs_fsm
  import bgs_pkg::*;
#(
  parameter int TURN_ON_CYC = 3,
  parameter int TIMEOUT_CYC = 20,
  parameter int BLANK_CYC   = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  tgt_e tgt,
  input  logic run_ok,
  input  logic hs_low_s,
  input  logic ls_low_s,
  input  logic zc_s,
  output logic hs_drive,
  output logic ls_drive,
  output logic fault_timeout
);
  localparam int MAX_AB = (TURN_ON_CYC > TIMEOUT_CYC) ? TURN_ON_CYC : TIMEOUT_CYC;
  localparam int MAX_C  = (MAX_AB > BLANK_CYC) ? MAX_AB : BLANK_CYC;
  localparam int CW     = $clog2(MAX_C + 1);
  localparam logic [CW-1:0] TON_LAST = CW'(TURN_ON_CYC - 1);
  localparam logic [CW-1:0] TMO_LAST = CW'(TIMEOUT_CYC - 1);
  localparam logic [CW-1:0] BLK_LAST = CW'(BLANK_CYC - 1);

  seq_st_e       st, st_nxt;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          fault_q, fault_set;

  always_comb begin
    st_nxt    = st;
    cnt_nxt   = cnt;
    fault_set = 1'b0;
    if (!run_ok) begin
      st_nxt  = ST_IDLE;
      cnt_nxt = '0;
    end else if (tgt == TGT_HS) begin
      unique case (st)
        ST_HS_ON: ;
        ST_HS_DLY: begin
          if (cnt == TON_LAST) begin st_nxt = ST_HS_ON; cnt_nxt = '0; end
          else cnt_nxt = cnt + 1'b1;
        end
        ST_WAIT_LS_OFF: begin
          if (ls_low_s) begin
            st_nxt = ST_HS_DLY; cnt_nxt = '0;
          end else if (cnt == TMO_LAST) begin
            st_nxt = ST_HS_DLY; cnt_nxt = '0; fault_set = 1'b1;
          end else cnt_nxt = cnt + 1'b1;
        end
        default: begin st_nxt = ST_WAIT_LS_OFF; cnt_nxt = '0; end
      endcase
    end else begin
      unique case (st)
        ST_LS_ON: begin
          if (tgt == TGT_DE) begin st_nxt = ST_DE_BLANK; cnt_nxt = '0; end
        end
        ST_DE_BLANK: begin
          if (tgt == TGT_LS) begin
            st_nxt = ST_LS_ON; cnt_nxt = '0;
          end else if (cnt == BLK_LAST) begin
            st_nxt = ST_DE_MON; cnt_nxt = '0;
          end else cnt_nxt = cnt + 1'b1;
        end
        ST_DE_MON: begin
          if (tgt == TGT_LS) st_nxt = ST_LS_ON;
          else if (zc_s)     st_nxt = ST_DE_DONE;
        end
        ST_DE_DONE: begin
          if (tgt == TGT_LS) begin st_nxt = ST_WAIT_HS_OFF; cnt_nxt = '0; end
        end
        ST_LS_DLY: begin
          if (cnt == TON_LAST) begin
            st_nxt  = (tgt == TGT_DE) ? ST_DE_BLANK : ST_LS_ON;
            cnt_nxt = '0;
          end else cnt_nxt = cnt + 1'b1;
        end
        ST_WAIT_HS_OFF: begin
          if (hs_low_s) begin
            st_nxt = ST_LS_DLY; cnt_nxt = '0;
          end else if (cnt == TMO_LAST) begin
            st_nxt = ST_LS_DLY; cnt_nxt = '0; fault_set = 1'b1;
          end else cnt_nxt = cnt + 1'b1;
        end
        default: begin st_nxt = ST_WAIT_HS_OFF; cnt_nxt = '0; end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      fault_q <= 1'b0;
    end else begin
      st      <= st_nxt;
      cnt     <= cnt_nxt;
      fault_q <= fault_q | fault_set;
    end
  end

  assign hs_drive      = (st == ST_HS_ON);
  assign ls_drive      = (st == ST_LS_ON) || (st == ST_DE_BLANK) || (st == ST_DE_MON);
  assign fault_timeout = fault_q;

  // R3
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_drive && ls_drive));

  // R1
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> (!hs_drive && !ls_drive));

  // R4
  hs_after_ls_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_drive) |-> $past(!ls_drive));

  // R5
  ls_after_hs_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_drive) |-> $past(!hs_drive));

  // R7
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DE_BLANK && run_ok && tgt == TGT_DE) |=> ls_drive);

  // R11
  fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_timeout |=> fault_timeout);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq
  import bgs_pkg::*;
#(
  parameter int TURN_ON_CYC = 3,
  parameter int TIMEOUT_CYC = 20,
  parameter int BLANK_CYC   = 70,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_hi,
  input  logic pwm_mid,
  input  logic pwm_lo,
  input  logic en_hi,
  input  logic en_mid,
  input  logic en_lo,
  input  logic supply_ok,
  input  logic hs_gate_low,
  input  logic ls_gate_low,
  input  logic zero_cross,
  output logic hs_drive,
  output logic ls_drive,
  output logic fault_timeout
);
  localparam int NFLAG = 3;

  logic [NFLAG-1:0] flags_async, flags_s;
  tgt_e             tgt;
  logic             run_ok;

  assign flags_async = {zero_cross, ls_gate_low, hs_gate_low};

  bgs_sync #(.WIDTH(NFLAG), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (flags_async),
    .q     (flags_s)
  );

  bgs_decode u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwm_hi    (pwm_hi),
    .pwm_mid   (pwm_mid),
    .pwm_lo    (pwm_lo),
    .en_hi     (en_hi),
    .en_mid    (en_mid),
    .en_lo     (en_lo),
    .supply_ok (supply_ok),
    .tgt       (tgt),
    .run_ok    (run_ok)
  );

  bgs_fsm #(
    .TURN_ON_CYC (TURN_ON_CYC),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .BLANK_CYC   (BLANK_CYC)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .tgt           (tgt),
    .run_ok        (run_ok),
    .hs_low_s      (flags_s[0]),
    .ls_low_s      (flags_s[1]),
    .zc_s          (flags_s[2]),
    .hs_drive      (hs_drive),
    .ls_drive      (ls_drive),
    .fault_timeout (fault_timeout)
  );
endmodule

// File: tb/buck_gate_seq_tb_top.sv
`timescale 1ns/1ps
module buck_gate_seq_tb_top;
  localparam int TON   = 3;
  localparam int TMO   = 20;
  localparam int BLANK = 70;
  localparam int FB    = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic pwm_hi, pwm_mid, pwm_lo, en_hi, en_mid, en_lo, supply_ok;
  logic hs_gate_low, ls_gate_low, zero_cross;
  logic hs_drive, ls_drive, fault_timeout;

  int checks = 0;
  int errs   = 0;
  bit finished = 0;
  bit rnd_mode = 0;
  bit stuck_ls = 0;
  logic [7:0] hist_hs = '0, hist_ls = '0;

  // reference model state: 0 off,1 wait-ls-off,2 hs-delay,3 hs-on,4 wait-hs-off,
  // 5 ls-delay,6 ls-on,7 blank,8 watch,9 latched-off
  int m_ph = 0, m_cnt = 0;
  bit m_fault = 0;
  bit m_lb1, m_lb2, m_hb1, m_hb2, m_z1, m_z2;

  always #2.5 clk = ~clk;

  buck_gate_seq #(.TURN_ON_CYC(TON), .TIMEOUT_CYC(TMO), .BLANK_CYC(BLANK)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_mid(pwm_mid), .pwm_lo(pwm_lo),
    .en_hi(en_hi), .en_mid(en_mid), .en_lo(en_lo), .supply_ok(supply_ok),
    .hs_gate_low(hs_gate_low), .ls_gate_low(ls_gate_low), .zero_cross(zero_cross),
    .hs_drive(hs_drive), .ls_drive(ls_drive), .fault_timeout(fault_timeout));

  function automatic bit m_hs(); return m_ph == 3; endfunction
  function automatic bit m_ls(); return m_ph == 6 || m_ph == 7 || m_ph == 8; endfunction

  function automatic string ph_tag();
    if (m_ph == 0) return supply_ok ? "R2" : "R1";
    if (m_ph <= 3) return "R4";
    if (m_ph <= 6) return pwm_mid ? "R6" : "R5";
    if (m_ph == 7) return "R7";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_pwm(input int lvl);
    pwm_hi = (lvl == 0); pwm_lo = (lvl == 1); pwm_mid = (lvl == 2);
  endtask

  task automatic set_en(input int lvl);
    en_hi = (lvl == 0); en_mid = (lvl == 1); en_lo = (lvl == 2);
  endtask

  task automatic m_step();
    bit run, lb, hb, z;
    int tg;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_fault = 0;
      m_lb1 = 0; m_lb2 = 0; m_hb1 = 0; m_hb2 = 0; m_z1 = 0; m_z2 = 0;
      return;
    end
    run = supply_ok && en_hi;
    tg  = pwm_hi ? 0 : (pwm_lo ? 1 : 2);
    lb = m_lb2; hb = m_hb2; z = m_z2;
    m_lb2 = m_lb1; m_lb1 = ls_gate_low;
    m_hb2 = m_hb1; m_hb1 = hs_gate_low;
    m_z2  = m_z1;  m_z1  = zero_cross;
    if (!run) begin m_ph = 0; m_cnt = 0; end
    else if (tg == 0) begin
      case (m_ph)
        3: ;
        2: if (m_cnt == TON-1) begin m_ph = 3; m_cnt = 0; end else m_cnt++;
        1: if (lb) begin m_ph = 2; m_cnt = 0; end
           else if (m_cnt == TMO-1) begin m_ph = 2; m_cnt = 0; m_fault = 1; end
           else m_cnt++;
        default: begin m_ph = 1; m_cnt = 0; end
      endcase
    end else begin
      case (m_ph)
        6: if (tg == 2) begin m_ph = 7; m_cnt = 0; end
        7: if (tg == 1) begin m_ph = 6; m_cnt = 0; end
           else if (m_cnt == BLANK-1) begin m_ph = 8; m_cnt = 0; end
           else m_cnt++;
        8: if (tg == 1) m_ph = 6; else if (z) m_ph = 9;
        9: if (tg == 1) begin m_ph = 4; m_cnt = 0; end
        5: if (m_cnt == TON-1) begin m_ph = (tg == 2) ? 7 : 6; m_cnt = 0; end else m_cnt++;
        4: if (hb) begin m_ph = 5; m_cnt = 0; end
           else if (m_cnt == TMO-1) begin m_ph = 5; m_cnt = 0; m_fault = 1; end
           else m_cnt++;
        default: begin m_ph = 4; m_cnt = 0; end
      endcase
    end
  endtask

  // inputs are set just after a falling edge; the model steps on them,
  // the DUT samples them at the rising edge, outputs compared at next falling edge
  task automatic tick();
    if (rnd_mode) begin
      if ($urandom % 25 == 0) set_pwm($urandom % 3);
      if ($urandom % 200 == 0) set_en(($urandom % 4 == 0) ? 1 + ($urandom % 2) : 0);
      if (en_hi == 0 && $urandom % 60 == 0) set_en(0);
      if (supply_ok && $urandom % 400 == 0) supply_ok = 0;
      else if (!supply_ok && $urandom % 10 == 0) supply_ok = 1;
      zero_cross = ($urandom % 30 == 0);
    end
    hs_gate_low = !hist_hs[FB-1];
    ls_gate_low = stuck_ls ? 1'b0 : !hist_ls[FB-1];
    m_step();
    @(negedge clk);
    chk(!(hs_drive && ls_drive), "R3", {hs_drive, ls_drive}, 0);
    chk(hs_drive == m_hs(), ph_tag(), hs_drive, m_hs());
    chk(ls_drive == m_ls(), ph_tag(), ls_drive, m_ls());
    chk(fault_timeout == m_fault, "R10", fault_timeout, m_fault);
    hist_hs = {hist_hs[6:0], hs_drive};
    hist_ls = {hist_ls[6:0], ls_drive};
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      checks++; errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    int on_cnt;
    void'($urandom(32'h5eed_0417));
    rst_n = 0; supply_ok = 1; set_pwm(1); set_en(0);
    hs_gate_low = 1; ls_gate_low = 1; zero_cross = 0;
    @(negedge clk);
    repeat (3) tick();
    // R1 reset state
    chk(!hs_drive && !ls_drive, "R1", {hs_drive, ls_drive}, 0);
    chk(!fault_timeout, "R11", fault_timeout, 0);
    rst_n = 1;

    rnd_mode = 1;
    repeat (30000) tick();
    rnd_mode = 0;

    // directed: steady low command, low side on (R5)
    supply_ok = 1; set_en(0); set_pwm(1); zero_cross = 0;
    repeat (40) tick();
    chk(ls_drive && !hs_drive, "R5", ls_drive, 1);

    // R7 blanking with zero-cross held active
    set_pwm(2); zero_cross = 1;
    on_cnt = 0;
    for (int i = 0; i < 200; i++) begin
      tick();
      if (ls_drive) on_cnt++;
    end
    chk(on_cnt == BLANK + 1, "R7", on_cnt, BLANK + 1);
    // R8 latched off while mid
    chk(!hs_drive && !ls_drive, "R8", {hs_drive, ls_drive}, 0);

    // R9 latch cleared by low command
    set_pwm(1); zero_cross = 0;
    repeat (10) tick();
    chk(ls_drive == 1, "R9", ls_drive, 1);

    // R2 enable mid forces off within one edge
    set_en(1);
    tick();
    chk(!hs_drive && !ls_drive, "R2", {hs_drive, ls_drive}, 0);
    set_en(0);
    repeat (20) tick();

    // R1 supply loss forces off within one edge
    supply_ok = 0;
    tick();
    chk(!hs_drive && !ls_drive, "R1", {hs_drive, ls_drive}, 0);
    supply_ok = 1;
    repeat (20) tick();

    // R10 timeout with low-side flag stuck
    stuck_ls = 1; set_pwm(0);
    repeat (TMO + TON + 6) tick();
    chk(hs_drive == 1, "R10", hs_drive, 1);
    chk(fault_timeout == 1, "R10", fault_timeout, 1);

    // R11 fault stays set
    stuck_ls = 0; set_pwm(1);
    repeat (30) tick();
    chk(fault_timeout == 1, "R11", fault_timeout, 1);
    rst_n = 0;
    tick();
    chk(fault_timeout == 0, "R11", fault_timeout, 0);
    chk(!hs_drive && !ls_drive, "R1", {hs_drive, ls_drive}, 0);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule